// File: doc/BRIEF.md
# Microsecond Free-Running Timer with Tear-Free Byte Reads

This block keeps a 12-bit count that advances once per microsecond and wraps freely, so firmware can time events lasting up to about four milliseconds. A built-in prescaler divides the system clock down to the one-microsecond tick. Two fixed-period interrupt request pulses come from the count: a fast one every 128 µs and a slow one every 1.024 ms.

Firmware reads the count through a byte-wide, read-only register bus at two addresses. A read of the low-byte address returns count bits [7:0]. In the same cycle it copies bits [11:8] into a holding register. A read of the high-byte address returns that held nibble and not the live count. The two bytes therefore form one consistent 12-bit value, even when the second read comes long after the first.

Read data is registered. It appears in the cycle after the read strobe and stays unchanged until the next strobe. The interrupt pulses are registered as well, and each one lasts for one system clock cycle.

Top module: `snap_timer`

## Requirements
- R1: After reset the read data, both interrupt outputs, the count, the prescaler and the holding register are all zero, so a high-byte read with no earlier low-byte read returns 0x00.
- R2: The count advances by exactly one every CLKS_PER_US system clocks and wraps from 0xFFF to 0x000.
- R3: `irq_128us` is high for one cycle in the cycle after a tick that rolls count bits [6:0] from all ones to zero. It therefore repeats every 128 ticks, and while it is high the count shows bits [6:0] equal to zero.
- R4: `irq_1024us` is high for one cycle in the cycle after a tick that rolls count bits [9:0] from all ones to zero. It repeats every 1024 ticks and is always high together with `irq_128us`.
- R5: A read strobe at address 0x24 returns count bits [7:0] on `rd_data` in the next cycle.
- R6: A read at address 0x24 copies count bits [11:8] into the holding register. A later read at 0x25 returns that nibble, however many ticks pass between the two reads.
- R7: A read at address 0x25 returns the holding register in `rd_data[3:0]` and zero in `rd_data[7:4]`.
- R8: A read at any address other than 0x24 or 0x25 returns 0x00. Neither such a read nor a 0x25 read changes the holding register.
- R9: When a tick and a 0x24 read fall in the same cycle, the returned low byte and the captured nibble both come from the count before the increment.
- R10: `rd_data` keeps its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| rd_addr | input | 8 | Register address sampled with rd_en |
| rd_data | output | 8 | Registered read data, valid the cycle after rd_en |
| irq_128us | output | 1 | One-cycle pulse every 128 ticks |
| irq_1024us | output | 1 | One-cycle pulse every 1024 ticks |

## Verification
The bench builds the block with CLKS_PER_US set to 3 instead of the default 12. This makes a full 4096-tick wrap take about 12k clocks, so one run covers several wraps, dozens of slow interrupts and hundreds of fast ones. The small divisor also makes reads land on the tick cycle often, which exercises the same-cycle case. The 12-bit count width and both interrupt tap positions keep their default values, so the wrap and the rollover boundaries are the real ones.

// File: rtl/snap_timer_pkg.sv
package snap_timer_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_LO    = 2'd1,
    SEL_HI    = 2'd2,
    SEL_OTHER = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/us_prescaler.sv
module us_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    tick  = (pre_q == LAST);
    pre_d = tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assert_pre_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int W        = 12,
  parameter int FAST_LOG = 7,
  parameter int SLOW_LOG = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         irq_fast,
  output logic         irq_slow
);
  logic [W-1:0] cnt_d;
  logic         fast_d, slow_d;

  always_comb begin
    cnt_d  = tick ? cnt + 1'b1 : cnt;
    fast_d = tick && (&cnt[FAST_LOG-1:0]);
    slow_d = tick && (&cnt[SLOW_LOG-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      irq_fast <= 1'b0;
      irq_slow <= 1'b0;
    end else begin
      cnt      <= cnt_d;
      irq_fast <= fast_d;
      irq_slow <= slow_d;
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 1'b1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  assert_fast_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |-> cnt[FAST_LOG-1:0] == '0);
  assert_fast_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |=> !irq_fast);
  assert_slow_with_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_slow |-> irq_fast);
endmodule

// File: rtl/snap_readout.sv
module snap_readout
  import snap_timer_pkg::*;
#(
  parameter int          W       = 12,
  parameter int          AW      = 8,
  parameter logic [AW-1:0] LO_ADDR = 8'h24,
  parameter logic [AW-1:0] HI_ADDR = 8'h25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  cnt,
  output logic [7:0]    rd_data
);
  localparam int HW = W - 8;

  rd_sel_e       sel;
  logic [HW-1:0] hold_q, hold_d;
  logic [7:0]    rd_d;

  always_comb begin
    if (!rd_en)                sel = SEL_NONE;
    else if (rd_addr == LO_ADDR) sel = SEL_LO;
    else if (rd_addr == HI_ADDR) sel = SEL_HI;
    else                       sel = SEL_OTHER;
  end

  always_comb begin
    hold_d = hold_q;
    rd_d   = rd_data;
    case (sel)
      SEL_LO: begin
        rd_d   = cnt[7:0];
        hold_d = cnt[W-1:8];
      end
      SEL_HI:    rd_d = {{(8-HW){1'b0}}, hold_q};
      SEL_OTHER: rd_d = 8'h00;
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      rd_data <= 8'h00;
    end else begin
      hold_q  <= hold_d;
      rd_data <= rd_d;
    end
  end

  assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr == LO_ADDR) |=> $stable(hold_q));
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == LO_ADDR) |=> hold_q == $past(cnt[W-1:8]));
  assert_hi_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == HI_ADDR) |=> rd_data[7:HW] == '0);
  assert_idle_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/snap_timer.sv
module snap_timer #(
  parameter int CLKS_PER_US = 12,
  parameter int CNT_W       = 12,
  parameter int FAST_LOG    = 7,
  parameter int SLOW_LOG    = 10,
  parameter int ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq_128us,
  output logic              irq_1024us
);
  logic             tick;
  logic [CNT_W-1:0] cnt;

  us_prescaler #(.DIV(CLKS_PER_US)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  tick_counter #(.W(CNT_W), .FAST_LOG(FAST_LOG), .SLOW_LOG(SLOW_LOG)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cnt     (cnt),
    .irq_fast(irq_128us),
    .irq_slow(irq_1024us)
  );

  snap_readout #(.W(CNT_W), .AW(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .cnt    (cnt),
    .rd_data(rd_data)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == 8'h00 && !irq_128us && !irq_1024us));
endmodule

// File: tb/sim_snap_timer.sv
module sim_snap_timer;
  localparam int P = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       irq_128us, irq_1024us;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit go = 1'b0;
  longint cyc = 0;
  longint last_fast = -1;
  longint last_slow = -1;
  string req_tag = "R1";
  string prev_tag = "R1";

  int        m_pre = 0;
  logic [11:0] m_cnt = '0;
  logic [3:0]  m_hold = '0;
  logic [7:0]  m_rd = '0;
  logic        m_if = 1'b0, m_is = 1'b0;

  always #5 clk = ~clk;

  snap_timer #(.CLKS_PER_US(P)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_128us(irq_128us), .irq_1024us(irq_1024us)
  );

  function automatic logic [7:0] exp_read(logic [7:0] a, logic [11:0] c, logic [3:0] h);
    if (a == 8'h24)      return c[7:0];
    else if (a == 8'h25) return {4'h0, h};
    else                 return 8'h00;
  endfunction

  function automatic string tag_for(logic [7:0] a);
    if (a == 8'h24)      return "R5";
    else if (a == 8'h25) return "R7";
    else                 return "R8";
  endfunction

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=0x%0h expected=0x%0h", tag, cyc, act, exp);
    end
  endtask

  // reference model, written from the requirements
  always @(posedge clk) begin
    go <= 1'b1;
    if (!rst_n) begin
      m_pre <= 0; m_cnt <= '0; m_hold <= '0; m_rd <= '0; m_if <= 1'b0; m_is <= 1'b0;
      prev_tag <= "R1";
    end else begin
      m_pre <= (m_pre == P-1) ? 0 : m_pre + 1;
      if (m_pre == P-1) m_cnt <= m_cnt + 12'd1;
      m_if <= (m_pre == P-1) && (m_cnt[6:0] == 7'h7F);
      m_is <= (m_pre == P-1) && (m_cnt[9:0] == 10'h3FF);
      if (rd_en) begin
        m_rd <= exp_read(rd_addr, m_cnt, m_hold);
        if (rd_addr == 8'h24) m_hold <= m_cnt[11:8];
        prev_tag <= req_tag;
      end else begin
        prev_tag <= "R10";
      end
    end
  end

  always @(negedge clk) begin
    if (go && !done) begin
      cyc++;
      check(prev_tag, rd_data, m_rd);
      check("R3", irq_128us, m_if);
      check("R4", irq_1024us, m_is);
      if (irq_128us) begin
        if (last_fast >= 0) check("R3 period", cyc - last_fast, 128*P);
        last_fast = cyc;
      end
      if (irq_1024us) begin
        if (last_slow >= 0) check("R4 period", cyc - last_slow, 1024*P);
        last_slow = cyc;
      end
    end
  end

  task automatic rd(logic [7:0] a, string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; req_tag = tag;
    @(negedge clk);
    rd_en = 1'b0; rd_addr = 8'h00;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [3:0] nib;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", rd_data, 8'h00);
    check("R1", irq_128us, 1'b0);
    check("R1", irq_1024us, 1'b0);
    rst_n = 1'b1;
    rd(8'h25, "R1");
    @(negedge clk);
    check("R1", rd_data, 8'h00);

    // R6: capture survives a long gap with the live count moving on
    rd(8'h24, "R5");
    nib = m_cnt[11:8];
    idle(700 * P);
    rd(8'h25, "R6");
    check("R6", rd_data, {4'h0, nib});

    // R8: other-address read returns zero and leaves the capture alone
    rd(8'h24, "R5");
    nib = m_cnt[11:8];
    idle(300 * P);
    rd(8'h13, "R8");
    check("R8", rd_data, 8'h00);
    rd(8'h25, "R8");
    rd(8'h25, "R8");
    check("R8", rd_data, {4'h0, nib});

    // R9: low read on the tick cycle
    for (int k = 0; k < 4; k++) begin
      while (m_pre != P-1) @(negedge clk);
      rd_en = 1'b1; rd_addr = 8'h24; req_tag = "R9";
      @(negedge clk);
      rd_en = 1'b0;
      rd(8'h25, "R9");
      idle(37);
    end

    // random traffic
    for (int i = 0; i < 14000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) begin
        logic [7:0] a;
        int s;
        s = $urandom_range(0, 4);
        a = (s < 2) ? 8'h24 : (s < 4) ? 8'h25 : 8'($urandom_range(0, 255));
        rd(a, tag_for(a));
      end else begin
        idle(1 + $urandom_range(0, 4));
      end
    end

    // R2: wrap from 0xFFF to 0x000
    while (!(m_cnt == 12'hFFF && m_pre == P-1)) @(negedge clk);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'h24; req_tag = "R2";
    @(negedge clk);
    rd_en = 1'b0;
    check("R2", rd_data, 8'h00);
    rd(8'h25, "R2");
    check("R2", rd_data, 8'h00);
    idle(10);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog cycle=%0d actual=running expected=finished", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule